// File: doc/BRIEF.md
# Board Status and Control Register Target on I2C

This block is an I2C target that sits on a board-management bus. A bus master reads board status through it and sets one control bit. SCL and SDA come in as plain inputs and pass through synchronisers to the system clock. The block never drives SDA high. It only asserts `sda_oe`, which pulls the shared line low through an external open-drain driver.

A write transfer has three parts: the 7-bit device address, one index byte, and then any number of data bytes. A read transfer returns bytes starting at the current index. A repeated START can follow a write of only the index byte, and that selects where a read begins. The readable bytes are:

- two fixed revision constants,
- the live power-group enable byte,
- the sixteen power-good inputs, split over two indices,
- the active-low sequencer fault flag,
- one writable control byte, whose bit 0 drives `aux_en_o`.

Clock stretching, 10-bit addressing and general call are not supported.

Top module: `brd_i2c_regs`

## Requirements
- R1: The block acknowledges a START followed by the 7-bit address 0x20 (address byte 0x40 write, 0x41 read) by pulling SDA low in the ninth clock. For any other address it leaves SDA released for the whole transfer.
- R2: Index 0x00 reads the constant 0x03 and index 0x01 reads the constant 0x02. Both are read-only.
- R3: Index 0x06 returns `grp_en_i`. Index 0x08 returns `pgood_i[7:0]` and index 0x09 returns `pgood_i[15:8]`. All three are sampled live when the byte is loaded for transmission.
- R4: Index 0x0A returns `{7'b0, fault_n_i}`.
- R5: Index 0x0E is a read/write byte that resets to 0x00. Bit 0 of that byte is `aux_en_o`, and `aux_en_o` changes only when this index is written.
- R6: A write to any index other than 0x0E is acknowledged and changes nothing. A read of an index outside {0x00, 0x01, 0x06, 0x08, 0x09, 0x0A, 0x0E} returns 0x00.
- R7: The first byte after a write address sets the index. Each data byte written or read then moves the index up by one, wrapping from 0xFF to 0x00.
- R8: A repeated START clears any SDA drive by the block. A following read address starts at the index left by the previous transfer.
- R9: After the master NACKs a read byte, the block keeps SDA released until the next START or STOP. A STOP also releases SDA.
- R10: The block starts pulling SDA low only while SCL is low. Read data goes out MSB first.
- R11: While and after reset, SDA is released and `aux_en_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen on the pin |
| sda_i | input | 1 | Bus data line as seen on the pin |
| sda_oe | output | 1 | 1 pulls SDA low; 0 releases it |
| grp_en_i | input | 8 | Power-group enable status byte |
| pgood_i | input | 16 | Debounced power-good vector |
| fault_n_i | input | 1 | Sequencer fault flag, active low |
| aux_en_o | output | 1 | External enable, bit 0 of the control byte |

## Verification
Two things can land on the same SCL falling edge: the write strobe to the control byte, and the index increment that a later read depends on. At that same edge the acknowledge drive also starts.

The bench provokes this overlap with a multi-byte write that runs across the control index. It follows that with a one-byte write and then an immediate repeated-START read. The result is judged in two ways: `aux_en_o` must follow only the byte that landed on index 0x0E, and the repeated-START read must return the byte at the advanced index.

A near-exhaustive sweep over indices 0x00 to 0x0F and a walking-one pattern over all sixteen power-good inputs compare each read against values the bench computes itself.

// File: rtl/brd_i2c_pkg.sv
package brd_i2c_pkg;

  typedef enum logic [2:0] {
    S_IDLE, S_ADDR, S_ADDR_ACK, S_RX, S_RX_ACK, S_TX, S_TX_ACK
  } tgt_st_t;

  localparam int PG_BITS = 16;
  localparam int BYTE_W  = 8;

  localparam logic [7:0] IX_FW    = 8'h00;
  localparam logic [7:0] IX_BRD   = 8'h01;
  localparam logic [7:0] IX_GRP   = 8'h06;
  localparam logic [7:0] IX_PG_LO = 8'h08;
  localparam logic [7:0] IX_PG_HI = 8'h09;
  localparam logic [7:0] IX_FLT   = 8'h0A;
  localparam logic [7:0] IX_CTL   = 8'h0E;

  // Read view of the whole register space; unmapped indices give zero.
  function automatic logic [7:0] reg_view(
    input logic [7:0]         ix,
    input logic [7:0]         fw,
    input logic [7:0]         brd,
    input logic [7:0]         grp,
    input logic [PG_BITS-1:0] pg,
    input logic               flt_n,
    input logic [7:0]         ctl
  );
    logic [7:0] v;
    case (ix)
      IX_FW:    v = fw;
      IX_BRD:   v = brd;
      IX_GRP:   v = grp;
      IX_PG_LO: v = pg[7:0];
      IX_PG_HI: v = pg[15:8];
      IX_FLT:   v = {7'd0, flt_n};
      IX_CTL:   v = ctl;
      default:  v = 8'h00;
    endcase
    return v;
  endfunction

  function automatic logic addr_hit(input logic [7:0] first, input logic [6:0] dev);
    return first[7:1] == dev;
  endfunction

endpackage

// File: rtl/brd_i2c_linesync.sv
module brd_i2c_linesync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);
  logic [STAGES-1:0] scl_p, sda_p;
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_p <= '1;
      sda_p <= '1;
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_p <= {scl_p[STAGES-2:0], scl_i};
      sda_p <= {sda_p[STAGES-2:0], sda_i};
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  assign scl_s    = scl_p[STAGES-1];
  assign sda_s    = sda_p[STAGES-1];
  assign scl_rise = scl_s & ~scl_q;
  assign scl_fall = ~scl_s & scl_q;
  // Data edges count only while the clock line stays high over both samples.
  assign start_ev = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_ev  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/brd_i2c_engine.sv
module brd_i2c_engine
  import brd_i2c_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h20
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sda_s,
  input  logic       scl_rise,
  input  logic       scl_fall,
  input  logic       start_ev,
  input  logic       stop_ev,
  input  logic [7:0] rd_data,
  output logic [7:0] ptr,
  output logic       wr_stb,
  output logic [7:0] wr_idx,
  output logic [7:0] wr_data,
  output logic       sda_oe
);
  localparam logic [3:0] BITS = 4'(BYTE_W);

  tgt_st_t    st;
  logic [3:0] cnt;
  logic [7:0] sh;
  logic       have_ix, rd_mode, nack, drive;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      cnt     <= '0;
      sh      <= '0;
      ptr     <= '0;
      have_ix <= 1'b0;
      rd_mode <= 1'b0;
      nack    <= 1'b1;
      drive   <= 1'b0;
      wr_stb  <= 1'b0;
      wr_idx  <= '0;
      wr_data <= '0;
    end else begin
      wr_stb <= 1'b0;
      if (start_ev) begin
        st    <= S_ADDR;
        cnt   <= '0;
        drive <= 1'b0;
      end else if (stop_ev) begin
        st    <= S_IDLE;
        drive <= 1'b0;
      end else begin
        case (st)
          S_ADDR, S_RX: begin
            if (scl_rise && cnt < BITS) begin
              sh  <= {sh[6:0], sda_s};
              cnt <= cnt + 4'd1;
            end else if (scl_fall && cnt == BITS) begin
              if (st == S_ADDR) begin
                if (addr_hit(sh, DEV_ADDR)) begin
                  drive   <= 1'b1;
                  rd_mode <= sh[0];
                  have_ix <= 1'b0;
                  st      <= S_ADDR_ACK;
                end else begin
                  st <= S_IDLE;
                end
              end else begin
                drive <= 1'b1;
                st    <= S_RX_ACK;
                if (!have_ix) begin
                  ptr     <= sh;
                  have_ix <= 1'b1;
                end else begin
                  wr_stb  <= 1'b1;
                  wr_idx  <= ptr;
                  wr_data <= sh;
                  ptr     <= ptr + 8'd1;
                end
              end
            end
          end
          S_ADDR_ACK: begin
            if (scl_fall) begin
              cnt <= '0;
              if (rd_mode) begin
                sh    <= rd_data;
                drive <= ~rd_data[7];
                ptr   <= ptr + 8'd1;
                st    <= S_TX;
              end else begin
                drive <= 1'b0;
                st    <= S_RX;
              end
            end
          end
          S_RX_ACK: begin
            if (scl_fall) begin
              drive <= 1'b0;
              cnt   <= '0;
              st    <= S_RX;
            end
          end
          S_TX: begin
            if (scl_fall) begin
              if (cnt == BITS - 4'd1) begin
                drive <= 1'b0;
                st    <= S_TX_ACK;
              end else begin
                sh    <= {sh[6:0], 1'b0};
                drive <= ~sh[6];
                cnt   <= cnt + 4'd1;
              end
            end
          end
          S_TX_ACK: begin
            if (scl_rise) begin
              nack <= sda_s;
            end else if (scl_fall) begin
              if (nack) begin
                st <= S_IDLE;
              end else begin
                sh    <= rd_data;
                drive <= ~rd_data[7];
                ptr   <= ptr + 8'd1;
                cnt   <= '0;
                st    <= S_TX;
              end
            end
          end
          default: st <= S_IDLE;
        endcase
      end
    end
  end

  assign sda_oe = drive;
endmodule

// File: rtl/brd_i2c_regbank.sv
module brd_i2c_regbank
  import brd_i2c_pkg::*;
#(
  parameter logic [7:0] FW_REV  = 8'h03,
  parameter logic [7:0] BRD_REV = 8'h02
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_stb,
  input  logic [7:0]         wr_idx,
  input  logic [7:0]         wr_data,
  input  logic [7:0]         rd_idx,
  input  logic [7:0]         grp_en_i,
  input  logic [PG_BITS-1:0] pgood_i,
  input  logic               fault_n_i,
  output logic [7:0]         rd_data,
  output logic [7:0]         ctl_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          ctl_q <= 8'h00;
    else if (wr_stb && wr_idx == IX_CTL) ctl_q <= wr_data;
  end

  assign rd_data = reg_view(rd_idx, FW_REV, BRD_REV, grp_en_i, pgood_i, fault_n_i, ctl_q);
endmodule

// File: rtl/brd_i2c_regs.sv
module brd_i2c_regs
  import brd_i2c_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'h20,
  parameter logic [7:0] FW_REV      = 8'h03,
  parameter logic [7:0] BRD_REV     = 8'h02,
  parameter int         SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               scl_i,
  input  logic               sda_i,
  output logic               sda_oe,
  input  logic [7:0]         grp_en_i,
  input  logic [PG_BITS-1:0] pgood_i,
  input  logic               fault_n_i,
  output logic               aux_en_o
);
  // Named internal events, also used by the bound checker.
  logic       scl_s, sda_s, scl_rise, scl_fall, start_ev, stop_ev;
  logic       wr_stb;
  logic [7:0] wr_idx, wr_data, ptr, rd_data, ctl_q;

  brd_i2c_linesync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_ev(start_ev), .stop_ev(stop_ev)
  );

  brd_i2c_engine #(.DEV_ADDR(DEV_ADDR)) u_eng (
    .clk(clk), .rst_n(rst_n), .sda_s(sda_s), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_ev(start_ev), .stop_ev(stop_ev),
    .rd_data(rd_data), .ptr(ptr), .wr_stb(wr_stb), .wr_idx(wr_idx),
    .wr_data(wr_data), .sda_oe(sda_oe)
  );

  brd_i2c_regbank #(.FW_REV(FW_REV), .BRD_REV(BRD_REV)) u_bank (
    .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_idx(wr_idx),
    .wr_data(wr_data), .rd_idx(ptr), .grp_en_i(grp_en_i), .pgood_i(pgood_i),
    .fault_n_i(fault_n_i), .rd_data(rd_data), .ctl_q(ctl_q)
  );

  assign aux_en_o = ctl_q[0];
endmodule

// File: rtl/brd_i2c_regs_chk.sv
module brd_i2c_regs_chk
  import brd_i2c_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       scl_s,
  input logic       sda_oe,
  input logic       start_ev,
  input logic       stop_ev,
  input logic       wr_stb,
  input logic [7:0] wr_idx,
  input logic [7:0] wr_data,
  input logic       aux_en_o
);
  AST_PULL_ONLY_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_s);                                              // R10
  AST_STOP_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    stop_ev |=> !sda_oe);                                                   // R9
  AST_START_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    start_ev |=> !sda_oe);                                                  // R8
  AST_CTL_TAKES_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && wr_idx == IX_CTL) |=> aux_en_o == $past(wr_data[0]));       // R5
  AST_OTHER_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && wr_idx != IX_CTL) |=> $stable(aux_en_o));                    // R6
  AST_AUX_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_stb |=> $stable(aux_en_o));                                         // R5
  AST_NO_EVENT_CLASH: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({start_ev, stop_ev, wr_stb}));                                 // R8
endmodule

bind brd_i2c_regs brd_i2c_regs_chk u_chk (
  .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_oe(sda_oe),
  .start_ev(start_ev), .stop_ev(stop_ev), .wr_stb(wr_stb),
  .wr_idx(wr_idx), .wr_data(wr_data), .aux_en_o(aux_en_o)
);

// File: tb/brd_i2c_regs_test.sv
module brd_i2c_regs_test;
  localparam int Q = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic [7:0]  grp = 8'h00;
  logic [15:0] pg = 16'h0000;
  logic        flt = 1'b1;
  logic [7:0]  ctl_exp = 8'h00;
  logic sda_oe, aux_en_o;
  wire  sda_bus = sda_m & ~sda_oe;

  int checks = 0, errors = 0, viol = 0, drive_seen = 0;
  logic watch = 1'b0, oe_prev = 1'b0, done = 1'b0;

  always #5 clk = ~clk;

  brd_i2c_regs uut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus), .sda_oe(sda_oe),
    .grp_en_i(grp), .pgood_i(pg), .fault_n_i(flt), .aux_en_o(aux_en_o)
  );

  // R10 monitor: a new pull-low must never start while SCL is high.
  always @(negedge clk) begin
    if (rst_n && sda_oe && !oe_prev && scl_m) viol++;
    if (watch && sda_oe) drive_seen++;
    oe_prev <= sda_oe;
  end

  function automatic logic [7:0] model(input logic [7:0] ix);
    case (ix)
      8'h00: return 8'h03;
      8'h01: return 8'h02;
      8'h06: return grp;
      8'h08: return pg[7:0];
      8'h09: return pg[15:8];
      8'h0A: return {7'd0, flt};
      8'h0E: return ctl_exp;
      default: return 8'h00;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", tag, got, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start;
    sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q);
    sda_m = 1'b0; tick(Q); scl_m = 1'b0; tick(Q);
  endtask

  task automatic bus_stop;
    sda_m = 1'b0; tick(Q); scl_m = 1'b1; tick(Q); sda_m = 1'b1; tick(Q);
  endtask

  task automatic clk_bit(input logic b, output logic s);
    sda_m = b; tick(Q); scl_m = 1'b1; tick(Q);
    s = sda_bus; tick(Q); scl_m = 1'b0; tick(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) clk_bit(b[i], s);
    clk_bit(1'b1, s);
    ack = ~s;
  endtask

  task automatic recv_byte(input logic last, output logic [7:0] b);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      clk_bit(1'b1, s);
      b[i] = s;
    end
    clk_bit(last, s);
  endtask

  // Write n bytes (low byte first) starting at index ix; returns AND of acks.
  task automatic wr_regs(input logic [7:0] ix, input logic [31:0] d, input int n,
                         output logic all_ack);
    logic a;
    bus_start;
    send_byte(8'h40, a); all_ack = a;
    send_byte(ix, a);    all_ack &= a;
    for (int k = 0; k < n; k++) begin
      send_byte(d[8*k +: 8], a);
      all_ack &= a;
    end
    bus_stop;
  endtask

  task automatic rd_regs(input logic [7:0] ix, input int n, output logic [31:0] got);
    logic a;
    logic [7:0] b;
    got = '0;
    bus_start;
    send_byte(8'h40, a);
    send_byte(ix, a);
    bus_start;
    send_byte(8'h41, a);
    for (int k = 0; k < n; k++) begin
      recv_byte(k == n - 1, b);
      got[8*k +: 8] = b;
    end
    bus_stop;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic a, s;
    logic [31:0] got;
    logic [7:0] b;

    tick(2);
    chk("R11 sda_oe in reset", {7'd0, sda_oe}, 8'h00);
    tick(3);
    rst_n = 1'b1;
    tick(4);
    chk("R11 sda_oe after reset", {7'd0, sda_oe}, 8'h00);
    chk("R11 aux_en after reset", {7'd0, aux_en_o}, 8'h00);

    // R1: wrong address gets no ACK and no drive
    drive_seen = 0; watch = 1'b1;
    bus_start; send_byte(8'h42, a); clk_bit(1'b1, s); bus_stop;
    watch = 1'b0;
    chk("R1 foreign address ack", {7'd0, a}, 8'h00);
    chk("R1 foreign address quiet", (drive_seen == 0) ? 8'h00 : 8'h01, 8'h00);
    bus_start; send_byte(8'h40, a); bus_stop;
    chk("R1 own address ack", {7'd0, a}, 8'h01);

    // R2 R7 R8: sequential read of the two constants
    rd_regs(8'h00, 2, got);
    chk("R2 fw revision", got[7:0], 8'h03);
    chk("R2 board revision R7", got[15:8], 8'h02);

    // R3 R4 R6: sweep of indices 0x00..0x0F
    grp = 8'h5A; pg = 16'hC3A5; flt = 1'b1;
    for (int ix = 0; ix < 16; ix++) begin
      rd_regs(8'(ix), 1, got);
      chk($sformatf("R6 sweep idx %02h (R3 R4)", ix), got[7:0], model(8'(ix)));
    end

    // R3: walking one over power-good inputs
    for (int k = 0; k < 16; k++) begin
      pg = 16'h0001 << k;
      rd_regs(8'h08, 2, got);
      chk($sformatf("R3 pg low bit %0d", k), got[7:0], pg[7:0]);
      chk($sformatf("R3 pg high bit %0d", k), got[15:8], pg[15:8]);
    end
    grp = 8'hA7;
    rd_regs(8'h06, 1, got);
    chk("R3 group enable", got[7:0], 8'hA7);

    flt = 1'b0;
    rd_regs(8'h0A, 1, got);
    chk("R4 fault low", got[7:0], 8'h00);
    flt = 1'b1;

    // R5: control byte
    wr_regs(8'h0E, 32'hA5, 1, a);
    ctl_exp = 8'hA5;
    chk("R5 write acked", {7'd0, a}, 8'h01);
    chk("R5 aux set", {7'd0, aux_en_o}, 8'h01);
    rd_regs(8'h0E, 1, got);
    chk("R5 readback", got[7:0], 8'hA5);
    wr_regs(8'h0E, 32'h00, 1, a);
    ctl_exp = 8'h00;
    chk("R5 aux cleared", {7'd0, aux_en_o}, 8'h00);

    // R6: read-only and unmapped writes ignored
    wr_regs(8'h00, 32'hFF, 1, a);
    chk("R6 ro write acked", {7'd0, a}, 8'h01);
    rd_regs(8'h00, 1, got);
    chk("R6 ro unchanged", got[7:0], 8'h03);
    wr_regs(8'h0F, 32'hFF, 1, a);
    chk("R6 aux after stray write", {7'd0, aux_en_o}, 8'h00);

    // R7: multi-byte write across the control index
    wr_regs(8'h0D, 32'h00_55_01_77, 3, a);
    ctl_exp = 8'h01;
    chk("R7 burst acked", {7'd0, a}, 8'h01);
    chk("R7 aux from burst", {7'd0, aux_en_o}, 8'h01);
    rd_regs(8'h0D, 3, got);
    chk("R7 burst rd 0D", got[7:0], 8'h00);
    chk("R7 burst rd 0E", got[15:8], 8'h01);
    chk("R7 burst rd 0F", got[23:16], 8'h00);
    rd_regs(8'hFF, 2, got);
    chk("R7 wrap FF", got[7:0], 8'h00);
    chk("R7 wrap to 00", got[15:8], 8'h03);

    // R8: data write advances pointer, restart read continues there
    bus_start; send_byte(8'h40, a); send_byte(8'h0D, a); send_byte(8'h99, a);
    bus_start; send_byte(8'h41, a);
    recv_byte(1'b1, b); bus_stop;
    chk("R8 restart read at advanced index", b, 8'h01);

    // R9: after NACK the target stays released
    bus_start; send_byte(8'h40, a); send_byte(8'h00, a);
    bus_start; send_byte(8'h41, a);
    recv_byte(1'b1, b);
    drive_seen = 0; watch = 1'b1;
    for (int k = 0; k < 9; k++) clk_bit(1'b1, s);
    watch = 1'b0;
    bus_stop;
    chk("R9 nacked byte value", b, 8'h03);
    chk("R9 released after nack", (drive_seen == 0) ? 8'h00 : 8'h01, 8'h00);
    chk("R9 released after stop", {7'd0, sda_oe}, 8'h00);

    chk("R10 no pull start while scl high", (viol == 0) ? 8'h00 : 8'h01, 8'h00);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule